// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block turns a 32-bit virtual address into a physical address at 4 KiB page granularity. Its sixteen entries are searched in parallel. Each request carries a virtual address, the identifier of the requesting process and a write flag. In the same cycle the block answers with exactly one outcome: a hit with the physical address and the page attributes, a miss, or a protection fault. A fault is raised when a write lands on a page held as read-only.

A miss only tells an external table walker to act. The walker later writes the mapping it found through a refill port. The block picks the slot itself. A slot that already holds the same page and process is reused. Otherwise the lowest empty slot is taken. If no slot is empty, the first slot not used recently is taken. If every slot has been used recently, slot 0 is replaced and all usage marks are cleared.

Each slot keeps a usage mark and a dirty mark. Successful accesses update them, and a hit reports both. Two invalidation inputs are provided: one discards every slot, and one discards only the slots of a given process.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `pa` holds the stored 20-bit frame number in bits 31:12, and bits 11:0 equal `req_va[11:0]`. The page number compared is `req_va[31:12]`.
- R2: A slot hits only when it is valid and its stored page number and process identifier both equal the request's. A request from another process, or for another page, misses.
- R3: With `req_valid` high, exactly one of `hit`, `miss`, `prot_fault` is high in the same cycle. With `req_valid` low, all three are low. Whenever `hit` is low, `pa`, `pa_writable`, `hit_refd` and `hit_dirty` are 0.
- R4: A write that matches a slot whose writable flag is 0 raises `prot_fault` and no `hit`. It leaves both the usage mark and the dirty mark of that slot unchanged. A read of the same slot hits with `pa_writable` = 0.
- R5: After a refill, a request for that page and process hits from the next cycle onward. A refill for a page and process already held overwrites that slot and creates no second copy. A freshly filled slot reports `hit_refd` = 0 and `hit_dirty` = 0.
- R6: `hit_refd` reports the usage mark as it was before the access. Every hit sets that mark at the next clock edge.
- R7: `hit_dirty` reports the dirty mark as it was before the access. Every write hit sets that mark at the next clock edge.
- R8: When a refill needs a new slot and at least one slot is empty, it takes the empty slot with the lowest index. Slots are numbered from 0. No valid mapping is evicted in that case.
- R9: When all slots are valid and some usage marks are clear, the refill replaces the lowest-indexed slot whose usage mark is clear.
- R10: When all slots are valid and all usage marks are set, the refill replaces slot 0 and clears the usage mark of every slot.
- R11: Reset, and `flush_all`, each leave every slot invalid at the next edge. After either, every request misses until a refill.
- R12: `flush_pid_en` invalidates at the next edge exactly the slots whose process identifier equals `flush_pid`. Other slots keep their mappings.
- R13: Edges where updates meet follow a fixed priority. A flush of either kind suppresses a refill and any mark update in its cycle, but the lookup in that cycle is still answered from the current contents. A refill wins over a hit update on the same slot. A hit on another slot during a refill that clears all usage marks keeps its own usage mark set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A translation request is present |
| req_va | input | 32 | Virtual address of the request |
| req_pid | input | 8 | Process identifier of the request |
| req_wr | input | 1 | Request is a write (1) or a read (0) |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No valid slot matches page and process |
| prot_fault | output | 1 | Write to a read-only page |
| pa | output | 32 | Physical address, 0 unless hit |
| pa_writable | output | 1 | Hit page may be written |
| hit_refd | output | 1 | Usage mark of the hit slot before this access |
| hit_dirty | output | 1 | Dirty mark of the hit slot before this access |
| fill_en | input | 1 | Write a mapping this cycle |
| fill_vpn | input | 20 | Page number of the mapping |
| fill_pid | input | 8 | Process identifier of the mapping |
| fill_pfn | input | 20 | Frame number of the mapping |
| fill_writable | input | 1 | Mapping allows writes |
| flush_all | input | 1 | Invalidate every slot |
| flush_pid_en | input | 1 | Invalidate the slots of one process |
| flush_pid | input | 8 | Process identifier for selective invalidation |

## Verification
A refill and a lookup hit can land in the same cycle. The interesting cases are when both touch the same slot, and when the refill clears every usage mark while the hit sets one. The bench drives the refill and the request together on one edge. It checks the outcome of that cycle at the ports, then issues follow-up reads whose `hit_refd`, `hit_dirty` and `pa` show which update won. A flush combined with a hit and a refill is provoked the same way. The bench checks that the cycle itself still hits, that the refilled page misses afterwards, and that so does the page that was hit.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PFN_W   = 20;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int PID_W   = 8;
    localparam int ENTRIES = 16;

    typedef logic [VPN_W-1:0]   vpn_t;
    typedef logic [PFN_W-1:0]   pfn_t;
    typedef logic [PID_W-1:0]   pid_t;
    typedef logic [ENTRIES-1:0] evec_t;

    // One stored translation
    typedef struct packed {
        logic valid;
        logic refd;
        logic dirty;
        logic wr_ok;
        pid_t pid;
        vpn_t vpn;
        pfn_t pfn;
    } tlb_ent_t;

    // Fields returned by a lookup
    typedef struct packed {
        logic wr_ok;
        logic refd;
        logic dirty;
        pfn_t pfn;
    } tlb_view_t;

    // Keep only the lowest set bit
    function automatic evec_t lowest_one(input evec_t v);
        return v & (~v + ENTRIES'(1));
    endfunction
endpackage

// File: rtl/tlb_cmp.sv
module tlb_cmp
    import tlbx_pkg::*;
(
    input  logic                   valid_v [ENTRIES],
    input  vpn_t                   vpn_a   [ENTRIES],
    input  pid_t                   pid_a   [ENTRIES],
    input  vpn_t                   key_vpn,
    input  pid_t                   key_pid,
    output evec_t                  match
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = valid_v[i] && (vpn_a[i] == key_vpn) && (pid_a[i] == key_pid);
    end
endmodule

// File: rtl/tlb_rdmux.sv
module tlb_rdmux
    import tlbx_pkg::*;
(
    input  evec_t     match,
    input  pfn_t      pfn_a   [ENTRIES],
    input  logic      wrok_v  [ENTRIES],
    input  logic      refd_v  [ENTRIES],
    input  logic      dirty_v [ENTRIES],
    output tlb_view_t view
);
    // AND-OR selection, one-hot match expected
    always_comb begin
        view = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                view.pfn   = view.pfn   | pfn_a[i];
                view.wr_ok = view.wr_ok | wrok_v[i];
                view.refd  = view.refd  | refd_v[i];
                view.dirty = view.dirty | dirty_v[i];
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlbx_pkg::*;
(
    input  evec_t same_v,
    input  evec_t valid_v,
    input  evec_t refd_v,
    output evec_t pick,
    output logic  clr_refs
);
    always_comb begin
        clr_refs = 1'b0;
        if (|same_v) begin
            pick = lowest_one(same_v);
        end else if (!(&valid_v)) begin
            pick = lowest_one(~valid_v);
        end else if (!(&refd_v)) begin
            pick = lowest_one(~refd_v);
        end else begin
            pick     = ENTRIES'(1);
            clr_refs = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush_all,
    input  logic     flush_pid_en,
    input  pid_t     flush_pid,
    input  logic     fill_en,
    input  evec_t    fill_pick,
    input  logic     fill_clr_refs,
    input  tlb_ent_t fill_ent,
    input  evec_t    acc_ok,
    input  logic     acc_wr,
    output tlb_ent_t ents [ENTRIES]
);
    tlb_ent_t nxt [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            nxt[i] = ents[i];
            if (flush_all) begin
                nxt[i].valid = 1'b0;
            end else if (flush_pid_en) begin
                if (ents[i].pid == flush_pid) nxt[i].valid = 1'b0;
            end else begin
                if (fill_en && fill_clr_refs) nxt[i].refd = 1'b0;
                if (acc_ok[i]) begin
                    nxt[i].refd = 1'b1;
                    if (acc_wr) nxt[i].dirty = 1'b1;
                end
                if (fill_en && fill_pick[i]) nxt[i] = fill_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) ents[i] <= '0;
            else     ents[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [PID_W-1:0] req_pid,
    input  logic             req_wr,
    output logic             hit,
    output logic             miss,
    output logic             prot_fault,
    output logic [PA_W-1:0]  pa,
    output logic             pa_writable,
    output logic             hit_refd,
    output logic             hit_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_writable,
    input  logic             flush_all,
    input  logic             flush_pid_en,
    input  logic [PID_W-1:0] flush_pid
);
    tlb_ent_t  ents [ENTRIES];
    logic      valid_u [ENTRIES];
    logic      refd_u  [ENTRIES];
    logic      dirty_u [ENTRIES];
    logic      wrok_u  [ENTRIES];
    vpn_t      vpn_a   [ENTRIES];
    pid_t      pid_a   [ENTRIES];
    pfn_t      pfn_a   [ENTRIES];
    evec_t     valid_v, refd_v;
    evec_t     lk_match, fl_match, fill_pick, acc_ok;
    logic      clr_refs, any_match;
    tlb_view_t view;
    tlb_ent_t  fill_ent;

    // Unpack slot fields for the compare, read and victim paths
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_u[i] = ents[i].valid;
            refd_u[i]  = ents[i].refd;
            dirty_u[i] = ents[i].dirty;
            wrok_u[i]  = ents[i].wr_ok;
            vpn_a[i]   = ents[i].vpn;
            pid_a[i]   = ents[i].pid;
            pfn_a[i]   = ents[i].pfn;
            valid_v[i] = ents[i].valid;
            refd_v[i]  = ents[i].refd;
        end
    end

    tlb_cmp u_lk_cmp (
        .valid_v (valid_u),
        .vpn_a   (vpn_a),
        .pid_a   (pid_a),
        .key_vpn (req_va[VA_W-1:OFF_W]),
        .key_pid (req_pid),
        .match   (lk_match)
    );

    tlb_cmp u_fl_cmp (
        .valid_v (valid_u),
        .vpn_a   (vpn_a),
        .pid_a   (pid_a),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .match   (fl_match)
    );

    tlb_rdmux u_rdmux (
        .match   (lk_match),
        .pfn_a   (pfn_a),
        .wrok_v  (wrok_u),
        .refd_v  (refd_u),
        .dirty_v (dirty_u),
        .view    (view)
    );

    tlb_victim u_victim (
        .same_v   (fl_match),
        .valid_v  (valid_v),
        .refd_v   (refd_v),
        .pick     (fill_pick),
        .clr_refs (clr_refs)
    );

    // Lookup outcome, all combinational
    assign any_match   = req_valid && (|lk_match);
    assign prot_fault  = any_match && req_wr && !view.wr_ok;
    assign hit         = any_match && !(req_wr && !view.wr_ok);
    assign miss        = req_valid && !(|lk_match);
    assign pa          = hit ? {view.pfn, req_va[OFF_W-1:0]} : '0;
    assign pa_writable = hit && view.wr_ok;
    assign hit_refd    = hit && view.refd;
    assign hit_dirty   = hit && view.dirty;
    assign acc_ok      = hit ? lk_match : '0;

    always_comb begin
        fill_ent       = '0;
        fill_ent.valid = 1'b1;
        fill_ent.wr_ok = fill_writable;
        fill_ent.pid   = fill_pid;
        fill_ent.vpn   = fill_vpn;
        fill_ent.pfn   = fill_pfn;
    end

    tlb_store u_store (
        .clk           (clk),
        .rst           (rst),
        .flush_all     (flush_all),
        .flush_pid_en  (flush_pid_en),
        .flush_pid     (flush_pid),
        .fill_en       (fill_en),
        .fill_pick     (fill_pick),
        .fill_clr_refs (clr_refs),
        .fill_ent      (fill_ent),
        .acc_ok        (acc_ok),
        .acc_wr        (req_wr),
        .ents          (ents)
    );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlbx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_wr,
    input logic            hit,
    input logic            miss,
    input logic            prot_fault,
    input logic [PA_W-1:0] pa,
    input logic            flush_all,
    input evec_t           lk_match
);
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones({hit, miss, prot_fault}) == 1);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(hit || miss || prot_fault));

    a_r3_pa_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |-> pa == '0);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        hit |-> pa[OFF_W-1:0] == req_va[OFF_W-1:0]);

    a_r4_fault_on_write: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> req_wr);

    a_r5_single_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !(hit || prot_fault));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_va     (req_va),
    .req_wr     (req_wr),
    .hit        (hit),
    .miss       (miss),
    .prot_fault (prot_fault),
    .pa         (pa),
    .flush_all  (flush_all),
    .lk_match   (lk_match)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_pid = '0;
    logic        req_wr = 1'b0;
    logic        hit, miss, prot_fault, pa_writable, hit_refd, hit_dirty;
    logic [31:0] pa;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_writable = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_pid_en = 1'b0;
    logic [7:0]  flush_pid = '0;

    int n_total = 0;
    int n_fail  = 0;

    // captured outputs of the last lookup
    logic [2:0]  o_kind;
    logic [31:0] o_pa;
    logic        o_wr, o_ref, o_dirty;

    localparam logic [2:0] K_HIT  = 3'b100;
    localparam logic [2:0] K_MISS = 3'b010;
    localparam logic [2:0] K_PROT = 3'b001;
    localparam logic [2:0] K_NONE = 3'b000;

    always #2 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_va(req_va), .req_pid(req_pid), .req_wr(req_wr),
        .hit(hit), .miss(miss), .prot_fault(prot_fault), .pa(pa),
        .pa_writable(pa_writable), .hit_refd(hit_refd), .hit_dirty(hit_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_pfn(fill_pfn), .fill_writable(fill_writable),
        .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic capture();
        o_kind  = {hit, miss, prot_fault};
        o_pa    = pa;
        o_wr    = pa_writable;
        o_ref   = hit_refd;
        o_dirty = hit_dirty;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [7:0] pid,
                            input logic [19:0] pfn, input logic wr_ok);
        fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn; fill_writable = wr_ok;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] pid,
                        input logic [19:0] pfn, input logic wr_ok);
        set_fill(vpn, pid, pfn, wr_ok);
        tick();
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] pid, input logic wr);
        req_valid = 1'b1; req_va = va; req_pid = pid; req_wr = wr;
        #1 capture();
        tick();
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    task automatic t_reset();
        #1 capture();
        chk("R3 idle outcome", 32'(o_kind), 32'(K_NONE));
        look(32'h1234_5678, 8'd3, 1'b0);
        chk("R11 miss after reset", 32'(o_kind), 32'(K_MISS));
        chk("R3 pa zero on miss", o_pa, 32'h0);
    endtask

    task automatic t_basic();
        fill(20'h12345, 8'd3, 20'hABCDE, 1'b1);
        look(32'h1234_5678, 8'd3, 1'b0);
        chk("R5 hit after fill", 32'(o_kind), 32'(K_HIT));
        chk("R1 physical address", o_pa, 32'hABCD_E678);
        chk("R1 writable attr", 32'(o_wr), 32'd1);
        chk("R6 fresh usage mark", 32'(o_ref), 32'd0);
        look(32'h1234_5FFF, 8'd3, 1'b0);
        chk("R6 usage mark set", 32'(o_ref), 32'd1);
        chk("R1 offset ffff", o_pa, 32'hABCD_EFFF);
        look(32'h1234_5000, 8'd3, 1'b1);
        chk("R7 write hits", 32'(o_kind), 32'(K_HIT));
        chk("R7 dirty before write", 32'(o_dirty), 32'd0);
        look(32'h1234_5000, 8'd3, 1'b0);
        chk("R7 dirty after write", 32'(o_dirty), 32'd1);
        look(32'h1234_5678, 8'd4, 1'b0);
        chk("R2 other process misses", 32'(o_kind), 32'(K_MISS));
        look(32'h1234_6000, 8'd3, 1'b0);
        chk("R2 other page misses", 32'(o_kind), 32'(K_MISS));
    endtask

    task automatic t_protect();
        fill(20'h00400, 8'd3, 20'h00055, 1'b0);
        look(32'h0040_0ABC, 8'd3, 1'b1);
        chk("R4 write to read-only", 32'(o_kind), 32'(K_PROT));
        chk("R4 no address on fault", o_pa, 32'h0);
        look(32'h0040_0ABC, 8'd3, 1'b0);
        chk("R4 read of read-only", 32'(o_kind), 32'(K_HIT));
        chk("R4 read-only address", o_pa, 32'h0005_5ABC);
        chk("R4 not writable", 32'(o_wr), 32'd0);
        chk("R4 fault left dirty clear", 32'(o_dirty), 32'd0);
        chk("R4 fault left usage clear", 32'(o_ref), 32'd0);
    endtask

    task automatic t_overwrite();
        fill(20'h12345, 8'd3, 20'h11111, 1'b0);
        look(32'h1234_5678, 8'd3, 1'b0);
        chk("R5 overwrite address", o_pa, 32'h1111_1678);
        chk("R5 overwrite attr", 32'(o_wr), 32'd0);
        chk("R5 overwrite usage", 32'(o_ref), 32'd0);
        chk("R5 overwrite dirty", 32'(o_dirty), 32'd0);
    endtask

    task automatic t_flush_pid();
        fill(20'h00777, 8'd5, 20'h00333, 1'b1);
        flush_pid_en = 1'b1; flush_pid = 8'd3;
        set_fill(20'h00888, 8'd3, 20'h00444, 1'b1);
        tick();
        flush_pid_en = 1'b0; fill_en = 1'b0;
        look(32'h1234_5000, 8'd3, 1'b0);
        chk("R12 process 3 page A gone", 32'(o_kind), 32'(K_MISS));
        look(32'h0040_0000, 8'd3, 1'b0);
        chk("R12 process 3 page B gone", 32'(o_kind), 32'(K_MISS));
        look(32'h0088_8000, 8'd3, 1'b0);
        chk("R13 fill dropped during flush", 32'(o_kind), 32'(K_MISS));
        look(32'h0077_7123, 8'd5, 1'b0);
        chk("R12 process 5 kept", o_pa, 32'h0033_3123);
    endtask

    task automatic t_flush_all();
        flush_all = 1'b1;
        req_valid = 1'b1; req_va = 32'h0077_7000; req_pid = 8'd5; req_wr = 1'b0;
        set_fill(20'h00999, 8'd5, 20'h00666, 1'b1);
        #1 capture();
        chk("R13 lookup served in flush cycle", 32'(o_kind), 32'(K_HIT));
        tick();
        flush_all = 1'b0; fill_en = 1'b0; req_valid = 1'b0;
        look(32'h0077_7000, 8'd5, 1'b0);
        chk("R11 flush empties", 32'(o_kind), 32'(K_MISS));
        look(32'h0099_9000, 8'd5, 1'b0);
        chk("R13 fill dropped during flush", 32'(o_kind), 32'(K_MISS));
    endtask

    function automatic logic [7:0] pid_of(input int i);
        return (i == 3 || i == 7) ? 8'd2 : 8'd1;
    endfunction

    task automatic t_replace();
        for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), pid_of(i), 20'h80000 + 20'(i), 1'b1);
        for (int i = 0; i < 5; i++) begin
            look({20'h00100 + 20'(i), 12'h000}, pid_of(i), 1'b0);
            chk("R8 slots filled in order", o_pa, {20'h80000 + 20'(i), 12'h000});
        end
        fill(20'h00200, 8'd1, 20'h90000, 1'b1);
        look(32'h0010_5000, 8'd1, 1'b0);
        chk("R9 first unused slot evicted", 32'(o_kind), 32'(K_MISS));
        look(32'h0020_0ABC, 8'd1, 1'b0);
        chk("R9 new mapping present", o_pa, 32'h9000_0ABC);
        look(32'h0010_4000, 8'd1, 1'b0);
        chk("R9 used slot kept", 32'(o_kind), 32'(K_HIT));
        look(32'h0010_6000, 8'd1, 1'b0);
        chk("R9 later slot kept", 32'(o_kind), 32'(K_HIT));
        for (int i = 7; i < 16; i++) look({20'h00100 + 20'(i), 12'h000}, pid_of(i), 1'b0);
    endtask

    task automatic t_sameclk();
        // every usage mark is set now
        set_fill(20'h00300, 8'd1, 20'hA0000, 1'b1);
        req_valid = 1'b1; req_va = 32'h0010_6000; req_pid = 8'd1; req_wr = 1'b0;
        #1 capture();
        chk("R13 hit beside refill", 32'(o_kind), 32'(K_HIT));
        chk("R13 mark seen before clear", 32'(o_ref), 32'd1);
        tick();
        fill_en = 1'b0; req_valid = 1'b0;
        look(32'h0010_0000, 8'd1, 1'b0);
        chk("R10 slot 0 replaced", 32'(o_kind), 32'(K_MISS));
        look(32'h0030_0000, 8'd1, 1'b0);
        chk("R10 new mapping present", o_pa, 32'hA000_0000);
        look(32'h0010_1000, 8'd1, 1'b0);
        chk("R10 marks cleared", 32'(o_ref), 32'd0);
        look(32'h0010_6000, 8'd1, 1'b0);
        chk("R13 concurrent hit kept mark", 32'(o_ref), 32'd1);
        // refill and write hit on the same slot
        set_fill(20'h00102, 8'd1, 20'hB0000, 1'b1);
        req_valid = 1'b1; req_va = 32'h0010_2000; req_pid = 8'd1; req_wr = 1'b1;
        #1 capture();
        chk("R13 old mapping in fill cycle", o_pa, 32'h8000_2000);
        tick();
        fill_en = 1'b0; req_valid = 1'b0; req_wr = 1'b0;
        look(32'h0010_2000, 8'd1, 1'b0);
        chk("R13 refill wins address", o_pa, 32'hB000_0000);
        chk("R13 refill wins dirty", 32'(o_dirty), 32'd0);
        // empty slot beats an unused valid slot
        flush_pid_en = 1'b1; flush_pid = 8'd2;
        tick();
        flush_pid_en = 1'b0;
        fill(20'h00400, 8'd1, 20'hC0000, 1'b1);
        look(32'h0010_4000, 8'd1, 1'b0);
        chk("R8 empty slot used first", 32'(o_kind), 32'(K_HIT));
        look(32'h0040_0000, 8'd1, 1'b0);
        chk("R8 mapping placed", o_pa, 32'hC000_0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL all watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_protect();
        t_overwrite();
        t_flush_pid();
        t_flush_all();
        t_replace();
        t_sameclk();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule